// File: doc/BRIEF.md
# Compare-and-Overflow Timer Channel

A single up-counting timer channel for a peripheral subsystem. Software programs a count, a compare value and a control word through a small write port. While the channel runs, the count advances on a clock enable taken from a selectable prescaler or from an external tick. It reports two events: the count reaching the compare value and the count wrapping past its top value.

Both events leave sticky flags in the upper bits of the control word. Software clears a flag by writing a one to it. A level interrupt request stays high while any flag whose interrupt is enabled remains set. Optional clear-on-match turns the channel into a periodic timer. A compare value written at or below the running count is held back until the count wraps, so a late write does not fire at once.

Top module: `cmp_ovf_timer`

## Requirements
- R1: After reset the count, compare value and control word read zero and `irq_o` is low.
- R2: While run (control bit 7) is clear, the count holds its value and no flag is set.
- R3: Control bits 1:0 pick the advance rate: 0 advances every clock, 1 every 16 clocks, 2 every 256 clocks, 3 on each clock that `ext_tick` is high. The prescaler restarts from zero when a control write sets run while run was clear.
- R4: With compare enable (bit 8) set, the step on which the count reaches or passes a nonzero compare value sets the match flag (bit 10) and raises `irq_o`. Without clear-on-match, no further match occurs until the count has wrapped.
- R5: A compare value of zero never produces a match.
- R6: Clear-on-match (bit 6) returns the count to zero on a match only while bit 8 is set. With bit 8 clear, bit 6 has no effect.
- R7: A step from 0xFFFF wraps the count to zero. The wrap flag (bit 11) is set only if its interrupt enable (bit 9) is set.
- R8: A control write (address 1) replaces bits 9:0. A one written to bit 10 or bit 11 clears that flag alone, and a zero leaves it. `irq_o` falls once no enabled flag remains.
- R9: A count write (address 0) loads the data at once and re-arms a match that was held back.
- R10: A compare write (address 2) with a nonzero value at or below the current count does not match until after the next wrap.
- R11: The compare check comes before the wrap check in the same step. A match with clear-on-match on the wrapping step zeroes the count and suppresses the wrap flag. Without clear-on-match, both flags are set on that step.
- R12: The count does not advance in a cycle that carries any write. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 count, 1 control, 2 compare, 3 unused |
| wr_data | input | 16 | Write data |
| ext_tick | input | 1 | External advance enable for rate 3 |
| count_o | output | 16 | Current count |
| mode_o | output | 12 | Control word including flags |
| target_o | output | 16 | Compare value |
| irq_o | output | 1 | Level interrupt request |

## Verification
Each test is a directed scenario. The counting path is tried at each of the four rates. The prescaler is stopped part way through a period and restarted, which separates a prescaler that restarts from one that keeps its phase. The compare path is run with a compare value ahead of the count, with zero, with a value equal to the count, and with a value reached on the wrapping step. These cases separate a correct match from an early match, from a zero-value match and from wrong ordering against the wrap. Flag handling is checked by writing ones and zeros to the flag bits. That shows whether clearing is selective and whether `irq_o` follows the enabled flags.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned MODE_W   = 12;
  localparam int unsigned B_RATE0  = 0;
  localparam int unsigned B_RATE1  = 1;
  localparam int unsigned B_CLRMT  = 6;
  localparam int unsigned B_RUN    = 7;
  localparam int unsigned B_CMPEN  = 8;
  localparam int unsigned B_OVFEN  = 9;
  localparam int unsigned B_MFLAG  = 10;
  localparam int unsigned B_OFLAG  = 11;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_TARGET = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned SH_A  = 4,
  parameter int unsigned SH_B  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] rate,
  input  logic       ext_tick,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;

  // Advance enable from the rate code and the prescaler phase.
  function automatic logic rate_tick(input logic [1:0] r,
                                     input logic [PRE_W-1:0] p,
                                     input logic ext);
    case (r)
      2'd0:    rate_tick = 1'b1;
      2'd1:    rate_tick = &p[SH_A-1:0];
      2'd2:    rate_tick = &p[SH_B-1:0];
      default: rate_tick = ext;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (run)     pre_q <= pre_q + 1'b1;
  end

  assign tick = rate_tick(rate, pre_q, ext_tick);
endmodule

// File: rtl/tmr_event.sv
module tmr_event #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             step,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] target,
  input  logic             held,
  input  logic             cmp_en,
  input  logic             clr_en,
  output logic             hit,
  output logic             wrap,
  output logic [CNT_W-1:0] nxt_count,
  output logic             nxt_held
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] ext;
  logic [EXT_W-1:0] after_cmp;
  logic             hit_raw;

  function automatic logic reached(input logic [EXT_W-1:0] e,
                                   input logic [CNT_W-1:0] t,
                                   input logic h, input logic en);
    reached = en && !h && (t != '0) && (e >= {1'b0, t});
  endfunction

  always_comb begin
    ext       = {1'b0, count} + 1'b1;
    hit_raw   = reached(ext, target, held, cmp_en);
    // compare first, then wrap
    after_cmp = (hit_raw && clr_en) ? '0 : ext;
    hit       = step && hit_raw;
    wrap      = step && after_cmp[CNT_W];
    nxt_count = after_cmp[CNT_W-1:0];
    if (after_cmp[CNT_W])       nxt_held = 1'b0;
    else if (hit_raw && !clr_en) nxt_held = 1'b1;
    else                         nxt_held = held;
  end
endmodule

// File: rtl/cmp_ovf_timer.sv
module cmp_ovf_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 8,
  parameter int unsigned SH_A  = 4,
  parameter int unsigned SH_B  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              ext_tick,
  output logic [CNT_W-1:0]  count_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [CNT_W-1:0]  target_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]  count_q, target_q, nxt_count;
  logic [MODE_W-1:0] mode_q;
  logic              held_q, nxt_held;
  logic              wr_cnt, wr_mode, wr_tgt, start, tick, step;
  logic              hit_evt, wrap_evt;

  assign wr_cnt  = wr_en && (wr_addr == SEL_COUNT);
  assign wr_mode = wr_en && (wr_addr == SEL_MODE);
  assign wr_tgt  = wr_en && (wr_addr == SEL_TARGET);
  assign start   = wr_mode && wr_data[B_RUN] && !mode_q[B_RUN];
  assign step    = mode_q[B_RUN] && tick && !wr_en;

  tmr_prescale #(.PRE_W(PRE_W), .SH_A(SH_A), .SH_B(SH_B)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(mode_q[B_RUN]), .restart(start),
    .rate(mode_q[B_RATE1:B_RATE0]), .ext_tick(ext_tick), .tick(tick)
  );

  tmr_event #(.CNT_W(CNT_W)) u_evt (
    .step(step), .count(count_q), .target(target_q), .held(held_q),
    .cmp_en(mode_q[B_CMPEN]), .clr_en(mode_q[B_CLRMT]),
    .hit(hit_evt), .wrap(wrap_evt), .nxt_count(nxt_count), .nxt_held(nxt_held)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      target_q <= '0;
      mode_q   <= '0;
      held_q   <= 1'b0;
    end else if (wr_cnt) begin
      count_q <= wr_data;
      held_q  <= 1'b0;
    end else if (wr_tgt) begin
      target_q <= wr_data;
      held_q   <= (wr_data != '0) && (wr_data <= count_q);
    end else if (wr_mode) begin
      mode_q[B_OVFEN:0] <= wr_data[B_OVFEN:0];
      mode_q[B_MFLAG]   <= mode_q[B_MFLAG] & ~wr_data[B_MFLAG];
      mode_q[B_OFLAG]   <= mode_q[B_OFLAG] & ~wr_data[B_OFLAG];
    end else if (step) begin
      count_q <= nxt_count;
      held_q  <= nxt_held;
      if (hit_evt)                     mode_q[B_MFLAG] <= 1'b1;
      if (wrap_evt && mode_q[B_OVFEN]) mode_q[B_OFLAG] <= 1'b1;
    end
  end

  assign count_o  = count_q;
  assign target_o = target_q;
  assign mode_o   = mode_q;
  assign irq_o    = (mode_q[B_MFLAG] && mode_q[B_CMPEN]) ||
                    (mode_q[B_OFLAG] && mode_q[B_OVFEN]);
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned MODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [CNT_W-1:0]  wr_data,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  target,
  input logic [MODE_W-1:0] mode,
  input logic              hit,
  input logic              wrap,
  input logic              irq
);
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[7] && !wr_en) |=> $stable(count));

  p_match_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> mode[10]);

  p_zero_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (target == '0) |-> !hit);

  p_clear_on_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode[6]) |=> (count == '0));

  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[10] && !(wr_en && wr_addr == 2'd1 && wr_data[10])) |=> mode[10]);

  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en));

  p_write_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 2'd0) |=> $stable(count));
endmodule

bind cmp_ovf_timer tmr_checker #(.CNT_W(CNT_W), .MODE_W(tmr_pkg::MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .count(count_q), .target(target_q), .mode(mode_q),
  .hit(hit_evt), .wrap(wrap_evt), .irq(irq_o)
);

// File: tb/sim_cmp_ovf_timer.sv
module sim_cmp_ovf_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        ext_tick = 1'b0;
  logic [15:0] count_o, target_o;
  logic [11:0] mode_o;
  logic        irq_o;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cmp_ovf_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_tick(ext_tick), .count_o(count_o),
    .mode_o(mode_o), .target_o(target_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 count", count_o, 0);
    chk("R1 mode", mode_o, 0);
    chk("R1 target", target_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_stopped;
    wr(2'd0, 16'd5);
    cyc(10);
    chk("R2 count held", count_o, 5);
    chk("R2 no flags", mode_o[11:10], 0);
  endtask

  task automatic t_rates;
    wr(2'd0, 16'd0); wr(2'd1, 16'h080); cyc(7);
    chk("R3 rate0", count_o, 7);
    wr(2'd1, 16'h000); wr(2'd0, 16'd0); wr(2'd1, 16'h081); cyc(15);
    chk("R3 rate1 before", count_o, 0);
    cyc(1);  chk("R3 rate1 first", count_o, 1);
    cyc(32); chk("R3 rate1 later", count_o, 3);
    wr(2'd1, 16'h000); wr(2'd0, 16'd0); wr(2'd1, 16'h082); cyc(255);
    chk("R3 rate2 before", count_o, 0);
    cyc(1); chk("R3 rate2 first", count_o, 1);
    wr(2'd1, 16'h000); wr(2'd0, 16'd0); wr(2'd1, 16'h083); cyc(5);
    chk("R3 ext idle", count_o, 0);
    for (int i = 0; i < 3; i++) begin
      ext_tick = 1'b1; cyc(1); ext_tick = 1'b0; cyc(2);
    end
    chk("R3 ext pulses", count_o, 3);
    // restart: stop mid-period, restart, full period needed
    wr(2'd1, 16'h000); wr(2'd0, 16'd0); wr(2'd1, 16'h081); cyc(10);
    wr(2'd1, 16'h001); wr(2'd0, 16'd0); wr(2'd1, 16'h081); cyc(15);
    chk("R3 restart phase", count_o, 0);
    cyc(1); chk("R3 restart tick", count_o, 1);
  endtask

  task automatic t_compare;
    wr(2'd1, 16'hC00); wr(2'd0, 16'd0); wr(2'd2, 16'd10); wr(2'd1, 16'h180);
    cyc(9);
    chk("R4 before match flag", mode_o[10], 0);
    chk("R4 before match irq", irq_o, 0);
    cyc(1);
    chk("R4 match count", count_o, 10);
    chk("R4 match flag", mode_o[10], 1);
    chk("R4 match irq", irq_o, 1);
    wr(2'd1, 16'h580); cyc(20);
    chk("R4 no rematch before wrap", mode_o[10], 0);
    chk("R8 irq cleared", irq_o, 0);
  endtask

  task automatic t_zero_target;
    wr(2'd1, 16'hC00); wr(2'd2, 16'd0); wr(2'd0, 16'hFFF0); wr(2'd1, 16'h180);
    cyc(40);
    chk("R5 zero target count", count_o, 16'h0018);
    chk("R5 zero target flag", mode_o[10], 0);
    chk("R7 wrap flag needs enable", mode_o[11], 0);
  endtask

  task automatic t_clear_on_match;
    wr(2'd1, 16'hC00); wr(2'd0, 16'd0); wr(2'd2, 16'd8); wr(2'd1, 16'h1C0);
    cyc(8);
    chk("R6 cleared on match", count_o, 0);
    chk("R6 flag", mode_o[10], 1);
    cyc(3); chk("R6 continues", count_o, 3);
    wr(2'd0, 16'd0); wr(2'd1, 16'h4C0); cyc(12);
    chk("R6 bit6 alone no clear", count_o, 12);
    chk("R6 bit6 alone no flag", mode_o[10], 0);
  endtask

  task automatic t_overflow;
    wr(2'd1, 16'hC00); wr(2'd2, 16'd0); wr(2'd0, 16'hFFFD); wr(2'd1, 16'h280);
    cyc(2);
    chk("R7 at top", count_o, 16'hFFFF);
    chk("R7 no flag yet", mode_o[11], 0);
    cyc(1);
    chk("R7 wrapped", count_o, 0);
    chk("R7 flag", mode_o[11], 1);
    chk("R7 irq", irq_o, 1);
    wr(2'd1, 16'h280);
    chk("R8 zero keeps flag", mode_o[11], 1);
    wr(2'd1, 16'h880);
    chk("R8 one clears flag", mode_o[11], 0);
    chk("R8 low bits replaced", mode_o[9:0], 10'h080);
    chk("R8 irq falls", irq_o, 0);
  endtask

  task automatic t_count_write;
    wr(2'd1, 16'hC00); wr(2'd0, 16'd0); wr(2'd2, 16'd10); wr(2'd1, 16'h180);
    cyc(10); wr(2'd1, 16'h580); cyc(3);
    chk("R9 held after match", mode_o[10], 0);
    wr(2'd0, 16'd20);
    chk("R9 load", count_o, 20);
    cyc(1);
    chk("R9 rearmed match", mode_o[10], 1);
  endtask

  task automatic t_late_target;
    wr(2'd1, 16'hC00); wr(2'd0, 16'd100); wr(2'd2, 16'd100); wr(2'd1, 16'h180);
    cyc(20);
    chk("R10 no early match", mode_o[10], 0);
    cyc(65515);
    chk("R10 just before", count_o, 99);
    chk("R10 still no flag", mode_o[10], 0);
    cyc(1);
    chk("R10 match after wrap", mode_o[10], 1);
  endtask

  task automatic t_order;
    wr(2'd1, 16'hC00); wr(2'd2, 16'd5); wr(2'd0, 16'hFFFF); wr(2'd1, 16'h3C0);
    cyc(1);
    chk("R11 clear count", count_o, 0);
    chk("R11 match flag", mode_o[10], 1);
    chk("R11 wrap suppressed", mode_o[11], 0);
    wr(2'd1, 16'hC00); wr(2'd2, 16'd5); wr(2'd0, 16'hFFFF); wr(2'd1, 16'h380);
    cyc(1);
    chk("R11 both count", count_o, 0);
    chk("R11 both match", mode_o[10], 1);
    chk("R11 both wrap", mode_o[11], 1);
  endtask

  task automatic t_unused;
    logic [15:0] c, t;
    logic [11:0] m;
    wr(2'd1, 16'h000);
    c = count_o; t = target_o; m = mode_o;
    wr(2'd3, 16'hFFFF);
    chk("R12 count", count_o, c);
    chk("R12 target", target_o, t);
    chk("R12 mode", mode_o, m);
    wr(2'd0, 16'd0); wr(2'd1, 16'h080); wr(2'd2, 16'd0); wr(2'd2, 16'd0);
    chk("R12 frozen during writes", count_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_stopped;
    t_rates;
    t_compare;
    t_zero_target;
    t_clear_on_match;
    t_overflow;
    t_count_write;
    t_late_target;
    t_order;
    t_unused;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule